// File: doc/BRIEF.md
# String-Skipping Sequential Fraction Multiplier

This block multiplies two unsigned binary fractions over many clock cycles and runs as a hardware subroutine of a larger controller. The controller presents a multiplicand, a multiplier and a step count, pulses `start`, and waits for `done`. The multiplicand is held in a register for the whole operation. The multiplier and a partial product then shift right together by one place per step. The low bit of the partial product enters the top of the multiplier register.

The block does not add once for every multiplier bit that is set. It keeps a run flag that records whether a string of ones is passing through the low end of the multiplier. When a string begins, it subtracts the multiplicand from the partial product. One place past the end of the string, it adds the multiplicand back. Every other step is a bare arithmetic shift. If a string is still open when the last step has been taken, one closing add is made without a shift. Each add or subtract waits a fixed pause for the adder to settle before the register loads, so the latency depends on the data.

The register and ALU function selects appear on output ports. A step count smaller than the fraction width stops the operation early and leaves the intermediate registers readable on the product outputs.

Top module: `fmul_string_skip`

## Requirements
- R1: With a step count equal to the fraction width W (16 by default), once `done` has risen, `{prod_hi, prod_lo}` equals the full 2W-bit unsigned product of `mcand_in` and `mplier_in`. The multiplicand register does not change while the operation runs.
- R2: Whenever `alu_fn` is 6 (subtract), `alu_cin` is 1, so the adder computes exactly A minus B with no extra borrow. Whenever `alu_fn` is 9 (add), `alu_cin` is 0.
- R3: `reg_fn` reads 0 for hold, 1 for a plain shift and 3 for a parallel load, and takes no other value. `alu_fn` reads 0, 6 or 9. During a plain shift `alu_fn` is 0. The number of load cycles equals the number of string boundaries met, counting a closing add.
- R4: While busy, every load cycle comes directly after exactly PAUSE_CYC (4 by default) consecutive hold cycles.
- R5: Count from the edge that accepts `start` to the edge after which `done` is first high. That count equals n + 4·k + 1 + f, where n is the step count, k is the number of add and subtract steps, and f is 1 when a closing add was needed.
- R6: With a step count n below W, the outputs show the registers part way through the operation. `{prod_hi, prod_lo}` equals (P << (W−n)) | (B >> n), where B is the multiplier and P = A · (B mod 2^n).
- R7: `done` is high for exactly one cycle, during which `busy` is low. The product outputs keep their value after `done`.
- R8: A `start` pulse while `busy` is high has no effect on the result or on the latency.
- R9: After reset, `busy`, `done`, `reg_fn`, `alu_fn`, `alu_cin`, `prod_hi` and `prod_lo` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when idle |
| mcand_in | input | FRAC_W | Multiplicand fraction |
| mplier_in | input | FRAC_W | Multiplier fraction |
| step_cnt | input | STEP_W | Number of shift steps to run |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| reg_fn | output | 2 | Register function select: 0 hold, 1 shift, 3 load |
| alu_fn | output | 4 | ALU function select: 0 none, 6 subtract, 9 add |
| alu_cin | output | 1 | Adder carry-in |
| prod_hi | output | FRAC_W | Upper half of product / partial product |
| prod_lo | output | FRAC_W | Lower half of product / multiplier register |

## Verification
The assertions assume that reset is held across at least one clock edge. They also assume that `step_cnt` is never larger than the fraction width, so that the partial product fits in its sign-extended register. The stimulus uses step counts from 0 to 16 only. It pulses `start` for a single cycle except in the scenario that deliberately pokes it while busy. Operands change only between operations, or during that scenario, when the block must ignore them.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    // Register function select codes (visible on reg_fn)
    typedef enum logic [1:0] {
        REG_HOLD  = 2'd0,
        REG_SHIFT = 2'd1,
        REG_LOAD  = 2'd3
    } reg_fn_e;

    // ALU function select codes (visible on alu_fn)
    typedef enum logic [3:0] {
        ALU_NONE = 4'd0,
        ALU_SUB  = 4'd6,
        ALU_ADD  = 4'd9
    } alu_fn_e;

    // Boundary classification of the current multiplier bit
    typedef enum logic [1:0] {
        EDGE_NONE  = 2'd0,
        EDGE_START = 2'd1,
        EDGE_END   = 2'd2
    } run_edge_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STEP  = 2'd1,
        ST_PAUSE = 2'd2,
        ST_OP    = 2'd3
    } seq_state_e;

    // Control bundle from sequencer to datapath
    typedef struct packed {
        reg_fn_e reg_fn;
        alu_fn_e alu_fn;
        logic    cin;
        logic    shift;
    } dp_ctl_t;

    function automatic run_edge_e classify_bit(input logic cur, input logic in_run);
        if (cur && !in_run)
            return EDGE_START;
        else if (!cur && in_run)
            return EDGE_END;
        else
            return EDGE_NONE;
    endfunction

endpackage

// File: rtl/fmul_run_recoder.sv
module fmul_run_recoder
    import fmul_pkg::*;
(
    input  logic      cur_bit,
    input  logic      run_flag,
    output run_edge_e edge_kind
);

    always_comb begin
        edge_kind = classify_bit(cur_bit, run_flag);
    end

endmodule

// File: rtl/fmul_seq_ctrl.sv
module fmul_seq_ctrl
    import fmul_pkg::*;
#(
    parameter int FRAC_W    = 16,
    parameter int PAUSE_CYC = 4,
    parameter int STEP_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [STEP_W-1:0] step_cnt,
    input  logic              q_lsb,
    output logic              capture,
    output dp_ctl_t           ctl,
    output logic              busy,
    output logic              done
);

    localparam int PCNT_W = (PAUSE_CYC > 2) ? $clog2(PAUSE_CYC) : 1;
    localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(PAUSE_CYC - 2);

    seq_state_e        state_q;
    logic [STEP_W-1:0] cnt_q;
    logic [PCNT_W-1:0] pcnt_q;
    logic              run_q;
    logic              pend_sub_q;
    logic              pend_final_q;
    logic              done_q;
    logic              cnt_done;
    run_edge_e         edge_kind;

    fmul_run_recoder u_recoder (
        .cur_bit   (q_lsb),
        .run_flag  (run_q),
        .edge_kind (edge_kind)
    );

    // Counter was loaded with the ones' complement of the count
    assign cnt_done = &cnt_q;
    assign capture  = (state_q == ST_IDLE) && start;
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;

    always_comb begin
        ctl = '{reg_fn: REG_HOLD, alu_fn: ALU_NONE, cin: 1'b0, shift: 1'b0};
        unique case (state_q)
            ST_STEP: begin
                if (!cnt_done && edge_kind == EDGE_NONE) begin
                    ctl.reg_fn = REG_SHIFT;
                    ctl.shift  = 1'b1;
                end
            end
            ST_PAUSE: begin
                ctl.alu_fn = pend_sub_q ? ALU_SUB : ALU_ADD;
                ctl.cin    = pend_sub_q;
            end
            ST_OP: begin
                ctl.reg_fn = REG_LOAD;
                ctl.alu_fn = pend_sub_q ? ALU_SUB : ALU_ADD;
                ctl.cin    = pend_sub_q;
                ctl.shift  = !pend_final_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            cnt_q        <= '0;
            pcnt_q       <= '0;
            run_q        <= 1'b0;
            pend_sub_q   <= 1'b0;
            pend_final_q <= 1'b0;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q   <= ~step_cnt;
                        run_q   <= 1'b0;
                        state_q <= ST_STEP;
                    end
                end
                ST_STEP: begin
                    if (cnt_done) begin
                        if (run_q) begin
                            pend_sub_q   <= 1'b0;
                            pend_final_q <= 1'b1;
                            pcnt_q       <= '0;
                            state_q      <= ST_PAUSE;
                        end else begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end else begin
                        unique case (edge_kind)
                            EDGE_START: begin
                                pend_sub_q   <= 1'b1;
                                pend_final_q <= 1'b0;
                                pcnt_q       <= '0;
                                state_q      <= ST_PAUSE;
                            end
                            EDGE_END: begin
                                pend_sub_q   <= 1'b0;
                                pend_final_q <= 1'b0;
                                pcnt_q       <= '0;
                                state_q      <= ST_PAUSE;
                            end
                            default: cnt_q <= cnt_q + 1'b1;
                        endcase
                    end
                end
                ST_PAUSE: begin
                    if (pcnt_q == PCNT_LAST)
                        state_q <= ST_OP;
                    else
                        pcnt_q <= pcnt_q + 1'b1;
                end
                ST_OP: begin
                    run_q <= pend_sub_q;
                    if (!pend_final_q)
                        cnt_q <= cnt_q + 1'b1;
                    state_q <= ST_STEP;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R7: completion is a single-cycle pulse seen only when idle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R3: a selected ALU function never coincides with a plain shift
    a_r3_no_alu_on_shift: assert property (@(posedge clk) disable iff (rst)
        (ctl.alu_fn != ALU_NONE) |-> (ctl.reg_fn != REG_SHIFT));
    // R8: a start while busy does not restart the operation
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !cnt_done) |=> busy);

endmodule

// File: rtl/fmul_frac_dp.sv
module fmul_frac_dp
    import fmul_pkg::*;
#(
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [FRAC_W-1:0] mcand_in,
    input  logic [FRAC_W-1:0] mplier_in,
    input  dp_ctl_t           ctl,
    output logic              q_lsb,
    output logic [FRAC_W-1:0] prod_hi,
    output logic [FRAC_W-1:0] prod_lo
);

    // Two extra bits: sign extension plus headroom after an add
    localparam int ACC_W = FRAC_W + 2;

    logic [FRAC_W-1:0] mcand_q;
    logic [FRAC_W-1:0] q_q;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  m_ext;
    logic [ACC_W-1:0]  addend;
    logic [ACC_W-1:0]  sum;

    assign m_ext  = {2'b00, mcand_q};
    assign addend = (ctl.alu_fn == ALU_SUB) ? ~m_ext : m_ext;
    assign sum    = acc_q + addend + {{(ACC_W-1){1'b0}}, ctl.cin};

    assign q_lsb   = q_q[0];
    assign prod_hi = acc_q[FRAC_W-1:0];
    assign prod_lo = q_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            q_q     <= '0;
            acc_q   <= '0;
        end else if (capture) begin
            mcand_q <= mcand_in;
            q_q     <= mplier_in;
            acc_q   <= '0;
        end else begin
            unique case (ctl.reg_fn)
                REG_SHIFT: begin
                    acc_q <= {acc_q[ACC_W-1], acc_q[ACC_W-1:1]};
                    q_q   <= {acc_q[0], q_q[FRAC_W-1:1]};
                end
                REG_LOAD: begin
                    if (ctl.shift) begin
                        acc_q <= {sum[ACC_W-1], sum[ACC_W-1:1]};
                        q_q   <= {sum[0], q_q[FRAC_W-1:1]};
                    end else begin
                        acc_q <= sum;
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: multiplicand register is frozen outside capture
    a_r1_mcand_held: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(mcand_q));
    // R6: a plain shift moves the partial product lsb into the multiplier msb
    a_r6_shift_chain: assert property (@(posedge clk) disable iff (rst)
        (!capture && ctl.reg_fn == REG_SHIFT) |=>
            (prod_lo == {$past(acc_q[0]), $past(q_q[FRAC_W-1:1])}));
    // R9: a hold cycle leaves the multiplier register untouched
    a_r9_hold_keeps: assert property (@(posedge clk) disable iff (rst)
        (!capture && ctl.reg_fn == REG_HOLD) |=> $stable(q_q));

endmodule

// File: rtl/fmul_string_skip.sv
module fmul_string_skip
    import fmul_pkg::*;
#(
    parameter  int FRAC_W    = 16,
    parameter  int PAUSE_CYC = 4,
    localparam int STEP_W    = $clog2(FRAC_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FRAC_W-1:0] mcand_in,
    input  logic [FRAC_W-1:0] mplier_in,
    input  logic [STEP_W-1:0] step_cnt,
    output logic              busy,
    output logic              done,
    output logic [1:0]        reg_fn,
    output logic [3:0]        alu_fn,
    output logic              alu_cin,
    output logic [FRAC_W-1:0] prod_hi,
    output logic [FRAC_W-1:0] prod_lo
);

    dp_ctl_t ctl;
    logic    capture;
    logic    q_lsb;

    fmul_seq_ctrl #(
        .FRAC_W    (FRAC_W),
        .PAUSE_CYC (PAUSE_CYC),
        .STEP_W    (STEP_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .step_cnt (step_cnt),
        .q_lsb    (q_lsb),
        .capture  (capture),
        .ctl      (ctl),
        .busy     (busy),
        .done     (done)
    );

    fmul_frac_dp #(
        .FRAC_W (FRAC_W)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .mcand_in  (mcand_in),
        .mplier_in (mplier_in),
        .ctl       (ctl),
        .q_lsb     (q_lsb),
        .prod_hi   (prod_hi),
        .prod_lo   (prod_lo)
    );

    assign reg_fn  = ctl.reg_fn;
    assign alu_fn  = ctl.alu_fn;
    assign alu_cin = ctl.cin;

    // Consecutive hold cycles while busy, for the pause check
    logic [7:0] hold_run_q;
    always_ff @(posedge clk) begin
        if (rst)
            hold_run_q <= '0;
        else if (busy && reg_fn == 2'd0)
            hold_run_q <= (hold_run_q == 8'hFF) ? hold_run_q : hold_run_q + 8'd1;
        else
            hold_run_q <= '0;
    end

    // R4: each load is preceded by exactly the propagation pause
    a_r4_pause_len: assert property (@(posedge clk) disable iff (rst)
        (reg_fn == 2'd3) |-> (hold_run_q == 8'(PAUSE_CYC)));
    // R2: carry-in level matches the ALU function
    a_r2_sub_no_borrow: assert property (@(posedge clk) disable iff (rst)
        (alu_fn == 4'd6) |-> alu_cin);
    a_r2_add_no_carry: assert property (@(posedge clk) disable iff (rst)
        (alu_fn == 4'd9) |-> !alu_cin);
    // R7: outputs hold once idle without a new start
    a_r7_result_held: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo)));

endmodule

// File: tb/fmul_string_skip_tb_top.sv
`timescale 1ns/1ps
module fmul_string_skip_tb_top;

    localparam int W     = 16;
    localparam int SW    = $clog2(W + 1);
    localparam int PAUSE = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [W-1:0]  mcand_in = '0;
    logic [W-1:0]  mplier_in = '0;
    logic [SW-1:0] step_cnt = '0;
    logic          busy, done, alu_cin;
    logic [1:0]    reg_fn;
    logic [3:0]    alu_fn;
    logic [W-1:0]  prod_hi, prod_lo;

    int tests_run = 0;
    int tests_failed = 0;

    always #2.5 clk = ~clk;

    fmul_string_skip #(.FRAC_W(W), .PAUSE_CYC(PAUSE)) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .mcand_in(mcand_in), .mplier_in(mplier_in), .step_cnt(step_cnt),
        .busy(busy), .done(done), .reg_fn(reg_fn), .alu_fn(alu_fn),
        .alu_cin(alu_cin), .prod_hi(prod_hi), .prod_lo(prod_lo)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                           input int n, input bit poke, input string req);
        longint unsigned mask, p, exp_v, got;
        int k, f, run, j, loads, holdrun, bad_cin, bad_code, bad_pause;
        mask = (n == 0) ? 64'd0 : ((64'd1 << n) - 64'd1);
        p = longint'(a) * (longint'(b) & mask);
        exp_v = (p << (W - n)) | (longint'(b) >> n);
        run = 0; k = 0; f = 0;
        for (int i = 0; i < n; i++) begin
            int bt;
            bt = int'(b[i]);
            if (bt != run) k++;
            run = bt;
        end
        if (run != 0) begin k++; f = 1; end

        @(negedge clk);
        mcand_in = a; mplier_in = b; step_cnt = SW'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        j = 0; loads = 0; holdrun = 0; bad_cin = 0; bad_code = 0; bad_pause = 0;
        while (!done && j < 2000) begin
            if (reg_fn == 2'd0) holdrun++;
            else begin
                if (reg_fn == 2'd3) begin
                    loads++;
                    if (holdrun != PAUSE) bad_pause++;
                end
                holdrun = 0;
            end
            if ((alu_fn == 4'd6 && !alu_cin) || (alu_fn == 4'd9 && alu_cin)) bad_cin++;
            if (!(reg_fn inside {2'd0, 2'd1, 2'd3}) || !(alu_fn inside {4'd0, 4'd6, 4'd9})
                || (reg_fn == 2'd1 && alu_fn != 4'd0)) bad_code++;
            if (poke && j == 2) begin
                start = 1'b1; mcand_in = ~a; mplier_in = ~b; step_cnt = SW'(3);
            end
            if (poke && j == 3) start = 1'b0;
            @(negedge clk);
            j++;
        end
        got = {prod_hi, prod_lo};
        // R1 / R6 / R8: product or partial readout (req names the case)
        check(got == exp_v, req, "product", got, exp_v);
        // R5: data-dependent latency
        check(j == n + 4 * k + 1 + f, "R5", "latency", longint'(j), longint'(n + 4 * k + 1 + f));
        // R3: load count equals boundary count
        check(loads == k, "R3", "load count", longint'(loads), longint'(k));
        check(bad_code == 0, "R3", "function codes", longint'(bad_code), 0);
        // R2: carry-in level during add/subtract
        check(bad_cin == 0, "R2", "carry-in", longint'(bad_cin), 0);
        // R4: pause before every load
        check(bad_pause == 0, "R4", "pause length", longint'(bad_pause), 0);
        @(negedge clk);
        // R7: single-cycle done, idle, result held
        check(!done && !busy, "R7", "done pulse", {62'd0, done, busy}, 0);
        check({prod_hi, prod_lo} == exp_v, "R7", "result held", {prod_hi, prod_lo}, exp_v);
    endtask

    task automatic t_reset();
        check(!busy && !done && reg_fn == 2'd0 && alu_fn == 4'd0 && !alu_cin,
              "R9", "control after reset", {busy, done, reg_fn, alu_fn, alu_cin}, 0);
        check(prod_hi == '0 && prod_lo == '0, "R9", "product after reset",
              {prod_hi, prod_lo}, 0);
    endtask

    task automatic t_unit_mcand();
        run_mul(16'h8000, 16'h6666, W, 1'b0, "R1");
        run_mul(16'h8000, 16'h00C3, W, 1'b0, "R1");
    endtask

    task automatic t_alternating();
        run_mul(16'h1234, 16'h5555, W, 1'b0, "R1");
        run_mul(16'hBEEF, 16'h3333, W, 1'b0, "R1");
    endtask

    task automatic t_top_run();
        run_mul(16'hA5A5, 16'hF00F, W, 1'b0, "R1");
        run_mul(16'hFFFF, 16'hFFFF, W, 1'b0, "R1");
        run_mul(16'h7001, 16'h0000, W, 1'b0, "R1");
    endtask

    task automatic t_early_stop();
        run_mul(16'hC001, 16'h0F38, 5, 1'b0, "R6");
        run_mul(16'h9999, 16'hF0F0, 6, 1'b0, "R6");
        run_mul(16'h4321, 16'hABCD, 0, 1'b0, "R6");
        run_mul(16'h4321, 16'hABCD, 15, 1'b0, "R6");
    endtask

    task automatic t_busy_start();
        run_mul(16'h2468, 16'h7E7E, W, 1'b1, "R8");
    endtask

    task automatic t_mixed();
        logic [31:0] s;
        s = 32'h1ACE_5EED;
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] a, b;
            s = s * 32'd1664525 + 32'd1013904223;
            a = s[31:16];
            s = s * 32'd1664525 + 32'd1013904223;
            b = s[31:16];
            run_mul(a, b, W, 1'b0, "R1");
        end
    endtask

    initial begin
        #(5.0 * 150000);
        tests_run++;
        tests_failed++;
        $display("FAIL R5 watchdog expired: actual 0x0 expected 0x1");
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unit_mcand();
        t_alternating();
        t_top_run();
        t_early_stop();
        t_busy_start();
        t_mixed();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule